// File: doc/BRIEF.md
# ALU Status Flag Register

This block is the status register of a small 8-bit accumulator-style processor core. It keeps three arithmetic flags (zero, digit carry and carry), two bits that record why the core last woke or reset (time-out and power-down), and one bit that selects the data-memory bank. The core drives it with the operands of the current ALU operation and a flag-operation code. The block computes the flags itself, with add and subtract flags taken from a carry chain and rotate flags taken from the source operand.

The register also sits in the core's register file. It answers writes to one location in either data bank. When a single instruction both writes the register and updates flags, the flag logic owns the three flag bits and the written data for them is dropped. The time-out and power-down bits change only on power-up, watchdog-clear, sleep and watchdog-time-out strobes, so a write can leave a value different from the one written. The two top bits are reserved and always read 0.

Top module: `status_flag_reg`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `stat_q` reads 8'h18. The layout is: bit 5 bank select, bit 4 time-out, bit 3 power-down, bit 2 zero (Z), bit 1 digit carry (DC), bit 0 carry (C), bits 7:6 reserved and read 0. So time-out and power-down are 1 and all other bits are 0.
- R2: A write (`wr_en`=1) to address STAT_LOC or STAT_LOC+0x80 (03h or 83h by default) with `flag_op`=0 loads bank, Z, DC and C from `wr_data` bits 5, 2, 1 and 0 on the next clock. Writes to any other address change nothing. `bank_sel` follows bit 5 of `stat_q`.
- R3: Writes never change the time-out or power-down bits, and bits 7:6 of `stat_q` stay 0 whatever is written.
- R4: `flag_op`=1 (add) forms `opnd_a`+`opnd_b`. C takes the carry out of bit 7, DC takes the carry out of bit 3, and Z is 1 when the 8-bit sum is 0.
- R5: `flag_op`=2 (subtract) forms `opnd_a`-`opnd_b` as `opnd_a` + ~`opnd_b` + 1. C is 1 when `opnd_a` >= `opnd_b`, DC is 1 when the low nibble of a >= the low nibble of b (1 means no borrow), and Z is 1 when the difference is 0.
- R6: `flag_op`=3 (rotate right through carry) loads C with `opnd_a` bit 0. `flag_op`=4 (rotate left) loads C with `opnd_a` bit 7. Z and DC are unchanged.
- R7: `flag_op`=5 (logic result test) sets Z to 1 when `opnd_a` is 0 and to 0 otherwise. DC and C are unchanged.
- R8: `flag_op`=6 (clear) sets Z and leaves DC and C unchanged. Together with a write of 0 to the register it leaves the pattern 000u u1uu.
- R9: When any nonzero `flag_op` coincides with a write to the register, the written Z, DC and C bits are discarded and the flags follow R4 to R8. The bank bit still takes `wr_data` bit 5.
- R10: A single event strobe acts on the next clock: watchdog time-out clears time-out and leaves power-down; sleep sets time-out and clears power-down; watchdog clear and power-up set both bits.
- R11: Simultaneous strobes resolve in the order power-up, then time-out, then sleep, then watchdog clear. A time-out together with a write clears time-out and still loads the bank bit from the write.
- R12: With `flag_op`=0 and no write, Z, DC, C and bank hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_op | input | 3 | Flag operation: 0 none, 1 add, 2 subtract, 3 rotate right, 4 rotate left, 5 zero test, 6 clear |
| opnd_a | input | DATA_W | First ALU operand (source of rotates and zero test) |
| opnd_b | input | DATA_W | Second ALU operand |
| wr_en | input | 1 | Register-file write strobe |
| wr_addr | input | ADDR_W | Register-file write address |
| wr_data | input | 8 | Register-file write data |
| ev_power_up | input | 1 | Power-up event strobe |
| ev_wdt_clear | input | 1 | Watchdog clear event strobe |
| ev_sleep | input | 1 | Sleep event strobe |
| ev_wdt_timeout | input | 1 | Watchdog time-out event strobe |
| stat_q | output | 8 | Register read value |
| bank_sel | output | 1 | Data-memory bank select |

## Verification
The bench builds the block with its defaults: 8-bit operands, a 4-bit digit-carry boundary, 8-bit addresses and the register at 03h. With these values both mirrored addresses, 03h and 83h, can be reached, along with a neighbouring address that must be ignored. The same widths give sums that wrap to zero and subtractions that borrow across the nibble or across the whole byte. The vector table drives writes and flag operations in the same cycle, and several event strobes together, so that override and priority can be observed in `stat_q`.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_RRC  = 3'd3,
    OP_RLC  = 3'd4,
    OP_ZTST = 3'd5,
    OP_CLRZ = 3'd6
  } flag_op_e;

  // bit positions inside the 8-bit status word
  localparam int STAT_W   = 8;
  localparam int BIT_C    = 0;
  localparam int BIT_DC   = 1;
  localparam int BIT_Z    = 2;
  localparam int BIT_PD   = 3;
  localparam int BIT_TO   = 4;
  localparam int BIT_BANK = 5;
  localparam int NFLAG    = 3;

  // packed so that {z,dc,c} lines up with status bits 2:0
  typedef struct packed {
    logic z;
    logic dc;
    logic c;
  } flags_t;

endpackage

// File: rtl/sfr_alu_flags.sv
module sfr_alu_flags
  import sfr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  flag_op_e            op,
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  output flags_t              upd_en,
  output flags_t              upd_val
);

  localparam int PKT_W = DATA_W + 2;

  // returns {carry out of msb, carry out of nibble, sum}
  function automatic logic [PKT_W-1:0] add_with_carry(
    input logic [DATA_W-1:0] x,
    input logic [DATA_W-1:0] y,
    input logic              cin
  );
    logic [NIB_W:0]  lo;
    logic [DATA_W:0] full;
    lo   = {1'b0, x[NIB_W-1:0]} + {1'b0, y[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
    full = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
    return {full[DATA_W], lo[NIB_W], full[DATA_W-1:0]};
  endfunction

  function automatic logic is_zero(input logic [DATA_W-1:0] v);
    return (v == '0);
  endfunction

  logic [PKT_W-1:0] add_pkt;
  logic [PKT_W-1:0] sub_pkt;

  assign add_pkt = add_with_carry(a, b, 1'b0);
  assign sub_pkt = add_with_carry(a, ~b, 1'b1);

  always_comb begin
    upd_en  = '0;
    upd_val = '0;
    unique case (op)
      OP_ADD: begin
        upd_en  = '{z: 1'b1, dc: 1'b1, c: 1'b1};
        upd_val = '{z: is_zero(add_pkt[DATA_W-1:0]), dc: add_pkt[DATA_W], c: add_pkt[DATA_W+1]};
      end
      OP_SUB: begin
        upd_en  = '{z: 1'b1, dc: 1'b1, c: 1'b1};
        upd_val = '{z: is_zero(sub_pkt[DATA_W-1:0]), dc: sub_pkt[DATA_W], c: sub_pkt[DATA_W+1]};
      end
      OP_RRC: begin
        upd_en.c  = 1'b1;
        upd_val.c = a[0];
      end
      OP_RLC: begin
        upd_en.c  = 1'b1;
        upd_val.c = a[DATA_W-1];
      end
      OP_ZTST: begin
        upd_en.z  = 1'b1;
        upd_val.z = is_zero(a);
      end
      OP_CLRZ: begin
        upd_en.z  = 1'b1;
        upd_val.z = 1'b1;
      end
      default: ;
    endcase
  end

  // R5: subtract carry means no borrow, i.e. a >= b
  always_comb begin
    if (op == OP_SUB) begin
      sub_no_borrow_chk: assert (upd_val.c == (a >= b));
    end
  end

endmodule

// File: rtl/sfr_reset_cause.sv
module sfr_reset_cause (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_pwr,
  input  logic ev_tmo,
  input  logic ev_slp,
  input  logic ev_clr,
  output logic to_q,
  output logic pd_q
);

  // decoded event actions, priority power-up > time-out > sleep > clear
  logic act_pwr, act_tmo, act_slp, act_clr, any_evt;

  assign act_pwr = ev_pwr;
  assign act_tmo = ev_tmo & ~ev_pwr;
  assign act_slp = ev_slp & ~ev_pwr & ~ev_tmo;
  assign act_clr = ev_clr & ~ev_pwr & ~ev_tmo & ~ev_slp;
  assign any_evt = ev_pwr | ev_tmo | ev_slp | ev_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_q <= 1'b1;
      pd_q <= 1'b1;
    end else if (act_pwr || act_clr) begin
      to_q <= 1'b1;
      pd_q <= 1'b1;
    end else if (act_tmo) begin
      to_q <= 1'b0;
    end else if (act_slp) begin
      to_q <= 1'b1;
      pd_q <= 1'b0;
    end
  end

  // R10
  timeout_clears_to_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tmo && !ev_pwr |=> !to_q && (pd_q == $past(pd_q)));

  // R10
  sleep_clears_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_slp && !ev_pwr && !ev_tmo |=> to_q && !pd_q);

  // R11
  powerup_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pwr |=> to_q && pd_q);

  // R3
  cause_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_evt |=> $stable(to_q) && $stable(pd_q));

endmodule

// File: rtl/sfr_flag_bits.sv
module sfr_flag_bits #(
  parameter int NBITS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [NBITS-1:0] wr_bits,
  input  logic [NBITS-1:0] upd_en,
  input  logic [NBITS-1:0] upd_val,
  output logic [NBITS-1:0] q
);

  // any flag-affecting operation takes the whole flag group away from the write
  logic flag_owned;
  assign flag_owned = |upd_en;

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[i] <= 1'b0;
      end else if (flag_owned) begin
        if (upd_en[i]) q[i] <= upd_val[i];
      end else if (wr_hit) begin
        q[i] <= wr_bits[i];
      end
    end

    // R9
    write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_owned && !upd_en[i] |=> q[i] == $past(q[i]));

    // R9
    flag_logic_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en[i] |=> q[i] == $past(upd_val[i]));
  end

endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
  import sfr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NIB_W    = 4,
  parameter int ADDR_W   = 8,
  parameter int STAT_LOC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        flag_op,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              ev_power_up,
  input  logic              ev_wdt_clear,
  input  logic              ev_sleep,
  input  logic              ev_wdt_timeout,
  output logic [7:0]        stat_q,
  output logic              bank_sel
);

  localparam logic [ADDR_W-1:0] LOC_BANK0 = ADDR_W'(STAT_LOC);
  localparam logic [ADDR_W-1:0] LOC_BANK1 = LOC_BANK0 | (ADDR_W'(1) << (ADDR_W - 1));

  flag_op_e op_e;
  flags_t   upd_en, upd_val;
  logic     wr_hit;
  logic     bank_q, to_q, pd_q;
  logic [NFLAG-1:0] flag_q;
  logic     unused_wr_bits;

  assign op_e           = flag_op_e'(flag_op);
  assign wr_hit         = wr_en && ((wr_addr == LOC_BANK0) || (wr_addr == LOC_BANK1));
  assign unused_wr_bits = ^{wr_data[7:6], wr_data[BIT_TO], wr_data[BIT_PD]};

  sfr_alu_flags #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_alu_flags (
    .op      (op_e),
    .a       (opnd_a),
    .b       (opnd_b),
    .upd_en  (upd_en),
    .upd_val (upd_val)
  );

  sfr_flag_bits #(.NBITS(NFLAG)) u_flag_bits (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hit  (wr_hit),
    .wr_bits (wr_data[NFLAG-1:0]),
    .upd_en  (upd_en),
    .upd_val (upd_val),
    .q       (flag_q)
  );

  sfr_reset_cause u_reset_cause (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_pwr (ev_power_up),
    .ev_tmo (ev_wdt_timeout),
    .ev_slp (ev_sleep),
    .ev_clr (ev_wdt_clear),
    .to_q   (to_q),
    .pd_q   (pd_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bank_q <= 1'b0;
    else if (wr_hit) bank_q <= wr_data[BIT_BANK];
  end

  always_comb begin
    stat_q                    = '0;
    stat_q[BIT_BANK]          = bank_q;
    stat_q[BIT_TO]            = to_q;
    stat_q[BIT_PD]            = pd_q;
    stat_q[NFLAG-1:0]         = flag_q;
  end

  assign bank_sel = bank_q;

  // R2
  bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> bank_sel == $past(wr_data[BIT_BANK]));

  // R12
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(bank_sel));

  // R8
  clear_sets_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_e == OP_CLRZ |=> stat_q[BIT_Z]);

  // R12
  idle_flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_e == OP_NONE && !wr_hit |=> $stable(stat_q[NFLAG-1:0]));

endmodule

// File: tb/status_flag_reg_bench.sv
module status_flag_reg_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] flag_op = '0;
  logic [7:0] opnd_a = '0, opnd_b = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0;
  logic       ev_power_up = 1'b0, ev_wdt_clear = 1'b0, ev_sleep = 1'b0, ev_wdt_timeout = 1'b0;
  logic [7:0] stat_q;
  logic       bank_sel;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // bench model
  logic m_bank, m_to, m_pd, m_z, m_dc, m_c;

  always #2 clk = ~clk;

  status_flag_reg u_status_flag_reg (
    .clk(clk), .rst_n(rst_n), .flag_op(flag_op), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ev_power_up(ev_power_up), .ev_wdt_clear(ev_wdt_clear), .ev_sleep(ev_sleep),
    .ev_wdt_timeout(ev_wdt_timeout), .stat_q(stat_q), .bank_sel(bank_sel)
  );

  // {op, a, b, wr, addr, wdata, {pwr, tmo, slp, clr}}
  localparam int NV = 23;
  localparam logic [39:0] VEC [NV] = '{
    {3'd1, 8'h0F, 8'h01, 1'b0, 8'h00, 8'h00, 4'b0000},
    {3'd1, 8'hF0, 8'h10, 1'b0, 8'h00, 8'h00, 4'b0000},
    {3'd1, 8'hFF, 8'h01, 1'b0, 8'h00, 8'h00, 4'b0000},
    {3'd2, 8'h05, 8'h03, 1'b0, 8'h00, 8'h00, 4'b0000},
    {3'd2, 8'h03, 8'h05, 1'b0, 8'h00, 8'h00, 4'b0000},
    {3'd2, 8'h10, 8'h01, 1'b0, 8'h00, 8'h00, 4'b0000},
    {3'd2, 8'h42, 8'h42, 1'b0, 8'h00, 8'h00, 4'b0000},
    {3'd3, 8'h01, 8'h00, 1'b0, 8'h00, 8'h00, 4'b0000},
    {3'd4, 8'h7F, 8'h00, 1'b0, 8'h00, 8'h00, 4'b0000},
    {3'd5, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 4'b0000},
    {3'd5, 8'h80, 8'h00, 1'b0, 8'h00, 8'h00, 4'b0000},
    {3'd0, 8'h00, 8'h00, 1'b1, 8'h03, 8'hFF, 4'b0000},
    {3'd0, 8'h00, 8'h00, 1'b1, 8'h83, 8'h00, 4'b0000},
    {3'd0, 8'h00, 8'h00, 1'b1, 8'h04, 8'hFF, 4'b0000},
    {3'd1, 8'h01, 8'h01, 1'b1, 8'h03, 8'h27, 4'b0000},
    {3'd3, 8'h00, 8'h00, 1'b1, 8'h83, 8'h07, 4'b0000},
    {3'd6, 8'h00, 8'h00, 1'b1, 8'h03, 8'h00, 4'b0000},
    {3'd0, 8'h00, 8'h00, 1'b1, 8'h03, 8'h20, 4'b0100},
    {3'd0, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 4'b0010},
    {3'd0, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 4'b0001},
    {3'd0, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 4'b0110},
    {3'd0, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 4'b1100},
    {3'd0, 8'hAA, 8'h55, 1'b0, 8'h03, 8'hFF, 4'b0000}
  };

  function automatic string vec_tag(input logic [2:0] op, input logic wr, input logic [3:0] ev);
    if ($countones(ev) > 1) return "R11 event priority";
    if (ev != 0 && wr)      return "R11 event with write";
    if (ev != 0)            return "R10 single event";
    case (op)
      3'd1: return wr ? "R9 add over write" : "R4 add";
      3'd2: return "R5 subtract";
      3'd3, 3'd4: return wr ? "R9 rotate over write" : "R6 rotate";
      3'd5: return "R7 zero test";
      3'd6: return "R8 clear";
      default: return wr ? "R2 write" : "R12 idle";
    endcase
  endfunction

  function automatic logic [7:0] model_word();
    return {2'b00, m_bank, m_to, m_pd, m_z, m_dc, m_c};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_bank = 0; m_to = 1; m_pd = 1; m_z = 0; m_dc = 0; m_c = 0;
  endtask

  task automatic step(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
                      input logic wr, input logic [7:0] addr, input logic [7:0] wd,
                      input logic [3:0] ev);
    int ai, bi, s;
    bit hit;
    string tag;
    tag = vec_tag(op, wr, ev);
    flag_op = op; opnd_a = a; opnd_b = b; wr_en = wr; wr_addr = addr; wr_data = wd;
    {ev_power_up, ev_wdt_timeout, ev_sleep, ev_wdt_clear} = ev;
    // model: events by priority
    if (ev[3])      begin m_to = 1; m_pd = 1; end
    else if (ev[2]) m_to = 0;
    else if (ev[1]) begin m_to = 1; m_pd = 0; end
    else if (ev[0]) begin m_to = 1; m_pd = 1; end
    hit = wr && ((addr % 128) == 3);
    if (hit) m_bank = wd[5];
    if (hit && op == 0) begin m_z = wd[2]; m_dc = wd[1]; m_c = wd[0]; end
    ai = a; bi = b;
    case (op)
      3'd1: begin s = ai + bi; m_c = (s > 255); m_dc = ((ai % 16) + (bi % 16)) > 15; m_z = (s % 256) == 0; end
      3'd2: begin m_c = (ai >= bi); m_dc = (ai % 16) >= (bi % 16); m_z = (ai == bi); end
      3'd3: m_c = a[0];
      3'd4: m_c = a[7];
      3'd5: m_z = (ai == 0);
      3'd6: m_z = 1;
      default: ;
    endcase
    @(posedge clk);
    @(negedge clk);
    check(tag, stat_q, model_word());
    check({tag, " bank_sel"}, {7'd0, bank_sel}, {7'd0, m_bank});
    if (wr) check("R3 cause bits and reserved bits after write",
                  {stat_q[7:6], stat_q[4:3]}, {2'b00, m_to, m_pd});
    flag_op = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    {ev_power_up, ev_wdt_timeout, ev_sleep, ev_wdt_clear} = 4'b0000;
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 value during reset", stat_q, 8'h18);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 value after reset release", stat_q, 8'h18);

    for (int i = 0; i < NV; i++) begin
      logic [39:0] v;
      v = VEC[i];
      step(v[39:37], v[36:29], v[28:21], v[20], v[19:12], v[11:4], v[3:0]);
    end

    // R12 idle cycles leave everything alone
    step(3'd0, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 4'b0000);

    // R6 rotate left of 80h sets carry, then R5 borrow across whole byte
    step(3'd4, 8'h80, 8'h00, 1'b0, 8'h00, 8'h00, 4'b0000);
    step(3'd2, 8'h00, 8'h01, 1'b0, 8'h00, 8'h00, 4'b0000);

    // R1 reset in mid run restores the reset word
    step(3'd0, 8'h00, 8'h00, 1'b1, 8'h03, 8'h27, 4'b0010);
    rst_n = 1'b0;
    #1;
    model_reset();
    check("R1 mid-run reset", stat_q, 8'h18);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after mid-run reset", stat_q, 8'h18);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule